// File: doc/BRIEF.md
# Serial audio codec link framer

This block runs the bit-serial link between the chip and an external audio codec. It is clocked by the codec's bit clock, which runs at about 12 MHz. On the outgoing side it cycles through 256-bit frames without a break. Each frame is a 16-bit tag slot followed by twelve 20-bit slots. The block drives a frame sync that is high for exactly the tag slot, and it shifts the frame out MSB first. The tag announces which slots carry real data. Slot 1 carries a register address, slot 2 carries register write data, and slots 3 and 4 carry a left and right PCM sample.

On the incoming side the block captures the codec's serial data on the falling bit-clock edge and tracks the frame position. From each frame it recovers two things: the codec-ready flag from the received tag, and the recorded left/right samples from slots 3 and 4. On real boards the incoming data can lead the nominal timing by one bit. A parameter moves the capture position by one bit to cover that case.

The rest of the design hands over register commands and playback samples through two valid/ready handshakes. Each stream holds one item. An accepted item goes out in the next frame to start, and its ready returns high as that frame begins.

Top module: `codec_link_framer`

## Requirements
- R1: From the first clock edge after reset is released, the block repeats frames of exactly 256 bit-clock cycles. `link_sync` is high for exactly 16 consecutive cycles at the start of every frame and low for the other 240.
- R2: Frame position 0 is the first cycle in which `link_sync` is high, and `link_sdo` carries tag bit 15 in that cycle. Bits follow MSB first. The tag takes positions 0–15, and slot n (1..12) takes positions 16+20(n-1) to 35+20(n-1).
- R3: In the outgoing tag, bit 14 is set when a command is sent and bit 13 when write data is sent (a write command). Bits 12 and 11 are set when a sample pair is sent. Bit 15 is the OR of bits 14–11. Bits 10–0 are zero.
- R4: Slot 1 is {read flag, 7-bit address, 12 zero bits}, where the read flag is 1 for a read. Slot 2 is {16-bit data, 4 zero bits} for a write and all zeros for a read.
- R5: Slots 3 and 4 carry the 20-bit left and right samples, left-justified when PCM_W is less than 20. Any slot with no pending data is all zeros, and so are slots 5–12.
- R6: `cmd_ready`/`pcm_ready` are high while that stream holds nothing. Each takes one item when valid and ready are both high at a rising edge. After that, ready stays low until the next frame begins. The held item goes out in that frame, and ready is high again in its first cycle.
- R7: `link_sdi` is sampled on the falling edge. With RX_EARLY=0 the bit for frame position p is taken from the cycle at position p. With RX_EARLY=1 it is taken from the cycle at position p-1.
- R8: `codec_ready` holds received tag bit 15 of the latest frame. Received slots 1, 2 and 5–12 have no effect on any output.
- R9: `rec_left`/`rec_right` are the upper REC_W bits of received slots 3 and 4. Both update together with a one-cycle `rec_valid` pulse. That pulse falls in the cycle at position 96 with RX_EARLY=0, and at position 95 with RX_EARLY=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Codec bit clock |
| rst | input | 1 | Synchronous active-high reset |
| link_sync | output | 1 | Frame sync to codec |
| link_sdo | output | 1 | Serial data to codec |
| link_sdi | input | 1 | Serial data from codec |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command stream empty |
| cmd_read | input | 1 | 1 = read command |
| cmd_addr | input | 7 | Register address |
| cmd_data | input | 16 | Register write data |
| pcm_valid | input | 1 | Sample pair offered |
| pcm_ready | output | 1 | Sample stream empty |
| pcm_left | input | PCM_W | Left playback sample |
| pcm_right | input | PCM_W | Right playback sample |
| codec_ready | output | 1 | Received codec-ready flag |
| rec_valid | output | 1 | New recorded pair |
| rec_left | output | REC_W | Recorded left sample |
| rec_right | output | REC_W | Recorded right sample |

## Verification
The bench builds two copies of the block. Instance u0 uses PCM_W=20, REC_W=20 and RX_EARLY=0, and it carries all outgoing traffic and nominal-alignment capture. Instance u1 uses RX_EARLY=1 and REC_W=16, and it receives the same frames one bit earlier. This pair reaches both settings of the capture offset, including the wrap from position 255 into the next frame. It also covers truncation of recorded samples to their upper bits and the one-position shift of the `rec_valid` pulse.

// File: rtl/clf_pkg.sv
package clf_pkg;
  localparam int FRAME_LEN = 256;
  localparam int TAG_W     = 16;
  localparam int SLOT_W    = 20;
  localparam int NUM_SLOTS = 13;
  localparam int POS_W     = $clog2(FRAME_LEN);
  localparam int ADDR_W    = 7;
  localparam int CDATA_W   = 16;

  // first frame position of a slot
  function automatic int slot_start(int s);
    return (s == 0) ? 0 : TAG_W + SLOT_W * (s - 1);
  endfunction

  // last frame position of a slot
  function automatic int slot_end(int s);
    return slot_start(s) + ((s == 0) ? TAG_W : SLOT_W) - 1;
  endfunction

  // index of a slot's MSB in a frame vector whose bit FRAME_LEN-1 is position 0
  function automatic int slot_msb(int s);
    return FRAME_LEN - 1 - slot_start(s);
  endfunction
endpackage

// File: rtl/clf_frame_timer.sv
module clf_frame_timer
  import clf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  output logic [POS_W-1:0] pos,
  output logic             sync_o,
  output logic             frame_load
);
  logic [POS_W-1:0] pos_nxt;

  always_comb begin
    if (pos == POS_W'(FRAME_LEN - 1)) pos_nxt = '0;
    else                              pos_nxt = pos + 1'b1;
  end

  // the edge that moves the position to 0 starts a new frame
  assign frame_load = (pos_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos    <= POS_W'(FRAME_LEN - 1);
      sync_o <= 1'b0;
    end else begin
      pos    <= pos_nxt;
      sync_o <= (pos_nxt < POS_W'(TAG_W));
    end
  end

  // R1: position wraps after the last bit of a frame
  a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
    (pos == POS_W'(FRAME_LEN - 1)) |=> (pos == '0));
  // R1: sync drops exactly when the tag slot is over
  a_r1_sync_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_o) |-> (pos == POS_W'(TAG_W)));
  // R2: sync rises exactly at frame position 0
  a_r2_sync_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_o) |-> (pos == '0));
endmodule

// File: rtl/clf_tx_framer.sv
module clf_tx_framer
  import clf_pkg::*;
#(
  parameter int PCM_W = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_load,
  input  logic               cmd_valid,
  input  logic               cmd_read,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [CDATA_W-1:0] cmd_data,
  output logic               cmd_ready,
  input  logic               pcm_valid,
  input  logic [PCM_W-1:0]   pcm_left,
  input  logic [PCM_W-1:0]   pcm_right,
  output logic               pcm_ready,
  output logic               sdo
);
  localparam int MSB1 = slot_msb(1);
  localparam int MSB2 = slot_msb(2);
  localparam int MSB3 = slot_msb(3);
  localparam int MSB4 = slot_msb(4);
  localparam int PAD1 = SLOT_W - 1 - ADDR_W;
  localparam int PAD2 = SLOT_W - CDATA_W;

  logic               cmd_pend, pcm_pend;
  logic               cmd_rd_q;
  logic [ADDR_W-1:0]  cmd_addr_q;
  logic [CDATA_W-1:0] cmd_data_q;
  logic [PCM_W-1:0]   left_q, right_q;
  logic               cmd_take, pcm_take;

  assign cmd_take  = cmd_valid & ~cmd_pend;
  assign pcm_take  = pcm_valid & ~pcm_pend;
  assign cmd_ready = ~cmd_pend;
  assign pcm_ready = ~pcm_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_pend <= 1'b0;
      pcm_pend <= 1'b0;
    end else begin
      if (frame_load)    cmd_pend <= cmd_take;
      else if (cmd_take) cmd_pend <= 1'b1;
      if (frame_load)    pcm_pend <= pcm_take;
      else if (pcm_take) pcm_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_rd_q   <= 1'b0;
      cmd_addr_q <= '0;
      cmd_data_q <= '0;
      left_q     <= '0;
      right_q    <= '0;
    end else begin
      if (cmd_take) begin
        cmd_rd_q   <= cmd_read;
        cmd_addr_q <= cmd_addr;
        cmd_data_q <= cmd_data;
      end
      if (pcm_take) begin
        left_q  <= pcm_left;
        right_q <= pcm_right;
      end
    end
  end

  logic [SLOT_W-1:0] w1, w2, w3, w4;
  logic [TAG_W-1:0]  tag;
  logic              wr_send;

  assign wr_send = cmd_pend & ~cmd_rd_q;
  assign w1 = cmd_pend ? {cmd_rd_q, cmd_addr_q, {PAD1{1'b0}}} : '0;
  assign w2 = wr_send  ? {cmd_data_q, {PAD2{1'b0}}} : '0;

  generate
    if (PCM_W == SLOT_W) begin : g_pcm_full
      assign w3 = pcm_pend ? left_q  : '0;
      assign w4 = pcm_pend ? right_q : '0;
    end else begin : g_pcm_pad
      assign w3 = pcm_pend ? {left_q,  {(SLOT_W - PCM_W){1'b0}}} : '0;
      assign w4 = pcm_pend ? {right_q, {(SLOT_W - PCM_W){1'b0}}} : '0;
    end
  endgenerate

  assign tag = {(cmd_pend | pcm_pend), cmd_pend, wr_send, pcm_pend, pcm_pend,
                {(TAG_W - 5){1'b0}}};

  logic [FRAME_LEN-1:0] frame, sr;

  always_comb begin
    frame = '0;
    frame[FRAME_LEN-1 -: TAG_W] = tag;
    frame[MSB1 -: SLOT_W] = w1;
    frame[MSB2 -: SLOT_W] = w2;
    frame[MSB3 -: SLOT_W] = w3;
    frame[MSB4 -: SLOT_W] = w4;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      sdo <= 1'b0;
    end else if (frame_load) begin
      sr  <= {frame[FRAME_LEN-2:0], 1'b0};
      sdo <= frame[FRAME_LEN-1];
    end else begin
      sr  <= {sr[FRAME_LEN-2:0], 1'b0};
      sdo <= sr[FRAME_LEN-1];
    end
  end

  // R6: a held command stays held until a frame starts
  a_r6_cmd_hold: assert property (@(posedge clk) disable iff (rst)
    (cmd_pend && !frame_load) |=> cmd_pend);
  // R6: with nothing offered, ready returns at the frame start
  a_r6_ready_after_load: assert property (@(posedge clk) disable iff (rst)
    (frame_load && !cmd_valid) |=> cmd_ready);
  // R3: empty frame starts with a zero frame-valid bit
  a_r3_idle_tag: assert property (@(posedge clk) disable iff (rst)
    (frame_load && !cmd_pend && !pcm_pend) |=> !sdo);
  // R3: a frame with data starts with a set frame-valid bit
  a_r3_busy_tag: assert property (@(posedge clk) disable iff (rst)
    (frame_load && (cmd_pend || pcm_pend)) |=> sdo);
endmodule

// File: rtl/clf_rx_deframer.sv
module clf_rx_deframer
  import clf_pkg::*;
#(
  parameter int RX_EARLY = 0,
  parameter int REC_W    = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] pos,
  input  logic             sdi,
  output logic             codec_ready,
  output logic             rec_valid,
  output logic [REC_W-1:0] rec_left,
  output logic [REC_W-1:0] rec_right
);
  localparam int L_END = slot_end(3);
  localparam int R_END = slot_end(4);

  logic             smp;
  logic [POS_W-1:0] idx;
  logic [SLOT_W-2:0] sh;
  logic [SLOT_W-1:0] word;
  logic [REC_W-1:0] left_hold;

  always_ff @(negedge clk) begin
    if (rst) smp <= 1'b0;
    else     smp <= sdi;
  end

  generate
    if (RX_EARLY != 0) begin : g_early
      assign idx = (pos == POS_W'(FRAME_LEN - 1)) ? '0 : pos + 1'b1;
    end else begin : g_nominal
      assign idx = pos;
    end
  endgenerate

  assign word = {sh, smp};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh          <= '0;
      codec_ready <= 1'b0;
      rec_valid   <= 1'b0;
      rec_left    <= '0;
      rec_right   <= '0;
      left_hold   <= '0;
    end else begin
      sh        <= word[SLOT_W-2:0];
      rec_valid <= 1'b0;
      if (idx == '0) codec_ready <= smp;
      if (idx == POS_W'(L_END)) left_hold <= word[SLOT_W-1 -: REC_W];
      if (idx == POS_W'(R_END)) begin
        rec_left  <= left_hold;
        rec_right <= word[SLOT_W-1 -: REC_W];
        rec_valid <= 1'b1;
      end
    end
  end

  // R9: recorded pair strobe lasts one cycle
  a_r9_pulse: assert property (@(posedge clk) disable iff (rst)
    rec_valid |=> !rec_valid);
  // R9: recorded samples change only with the strobe
  a_r9_stable: assert property (@(posedge clk) disable iff (rst)
    !rec_valid |-> $stable(rec_right));
  // R8: ready flag changes only after the tag MSB position
  a_r8_ready_slot: assert property (@(posedge clk) disable iff (rst)
    !$stable(codec_ready) |-> ($past(idx) == '0));
endmodule

// File: rtl/codec_link_framer.sv
module codec_link_framer
  import clf_pkg::*;
#(
  parameter int PCM_W    = 20,
  parameter int REC_W    = 20,
  parameter int RX_EARLY = 0
) (
  input  logic               bit_clk,
  input  logic               rst,
  output logic               link_sync,
  output logic               link_sdo,
  input  logic               link_sdi,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_read,
  input  logic [6:0]         cmd_addr,
  input  logic [15:0]        cmd_data,
  input  logic               pcm_valid,
  output logic               pcm_ready,
  input  logic [PCM_W-1:0]   pcm_left,
  input  logic [PCM_W-1:0]   pcm_right,
  output logic               codec_ready,
  output logic               rec_valid,
  output logic [REC_W-1:0]   rec_left,
  output logic [REC_W-1:0]   rec_right
);
  logic [POS_W-1:0] pos;
  logic             frame_load;

  clf_frame_timer u_timer (
    .clk        (bit_clk),
    .rst        (rst),
    .pos        (pos),
    .sync_o     (link_sync),
    .frame_load (frame_load)
  );

  clf_tx_framer #(.PCM_W(PCM_W)) u_tx (
    .clk        (bit_clk),
    .rst        (rst),
    .frame_load (frame_load),
    .cmd_valid  (cmd_valid),
    .cmd_read   (cmd_read),
    .cmd_addr   (cmd_addr),
    .cmd_data   (cmd_data),
    .cmd_ready  (cmd_ready),
    .pcm_valid  (pcm_valid),
    .pcm_left   (pcm_left),
    .pcm_right  (pcm_right),
    .pcm_ready  (pcm_ready),
    .sdo        (link_sdo)
  );

  clf_rx_deframer #(.RX_EARLY(RX_EARLY), .REC_W(REC_W)) u_rx (
    .clk         (bit_clk),
    .rst         (rst),
    .pos         (pos),
    .sdi         (link_sdi),
    .codec_ready (codec_ready),
    .rec_valid   (rec_valid),
    .rec_left    (rec_left),
    .rec_right   (rec_right)
  );
endmodule

// File: tb/sim_codec_link_framer.sv
module sim_codec_link_framer;
  localparam int CLK_PERIOD = 80;
  localparam int NV = 6;
  localparam int NRX = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // vector: rd[65] addr[64:58] data[57:42] left[41:22] right[21:2] send_cmd[1] send_pcm[0]
  localparam logic [65:0] VEC [NV] = '{
    {1'b0, 7'h02, 16'h0808, 20'h00000, 20'h00000, 1'b1, 1'b0},
    {1'b0, 7'h00, 16'h0000, 20'h12345, 20'hFEDCB, 1'b0, 1'b1},
    {1'b0, 7'h18, 16'h0F0F, 20'h80001, 20'h7FFFE, 1'b1, 1'b1},
    {1'b1, 7'h26, 16'hFFFF, 20'h00000, 20'h00000, 1'b1, 1'b0},
    {1'b0, 7'h00, 16'h0000, 20'h00000, 20'h00000, 1'b0, 1'b0},
    {1'b0, 7'h7F, 16'hFFFF, 20'hFFFFF, 20'hFFFFF, 1'b1, 1'b1}
  };
  // rx vector: ready[40] left[39:20] right[19:0]
  localparam logic [40:0] RXV [NRX] = '{
    {1'b1, 20'hABCDE, 20'h13579},
    {1'b0, 20'h0F0F0, 20'hFFFFF},
    {1'b1, 20'h80008, 20'h00001}
  };

  logic        cmd_valid = 0, cmd_read = 0, pcm_valid = 0;
  logic [6:0]  cmd_addr = 0;
  logic [15:0] cmd_data = 0;
  logic [19:0] pcm_left = 0, pcm_right = 0;
  logic        sync0, sdo0, cmd_ready, pcm_ready, crdy0, rv0;
  logic [19:0] rl0, rr0;
  logic        sync1, sdo1, cr1, pr1, crdy1, rv1;
  logic [15:0] rl1, rr1;
  logic        sdi0, sdi1;

  codec_link_framer #(.PCM_W(20), .REC_W(20), .RX_EARLY(0)) u0 (
    .bit_clk(clk), .rst(rst), .link_sync(sync0), .link_sdo(sdo0), .link_sdi(sdi0),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_read(cmd_read),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .pcm_valid(pcm_valid),
    .pcm_ready(pcm_ready), .pcm_left(pcm_left), .pcm_right(pcm_right),
    .codec_ready(crdy0), .rec_valid(rv0), .rec_left(rl0), .rec_right(rr0));

  codec_link_framer #(.PCM_W(20), .REC_W(16), .RX_EARLY(1)) u1 (
    .bit_clk(clk), .rst(rst), .link_sync(sync1), .link_sdo(sdo1), .link_sdi(sdi1),
    .cmd_valid(1'b0), .cmd_ready(cr1), .cmd_read(1'b0),
    .cmd_addr(7'h0), .cmd_data(16'h0), .pcm_valid(1'b0),
    .pcm_ready(pr1), .pcm_left(20'h0), .pcm_right(20'h0),
    .codec_ready(crdy1), .rec_valid(rv1), .rec_left(rl1), .rec_right(rr1));

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [255:0] exp_frame(logic [65:0] v);
    logic [255:0] f;
    logic rd, sc, sp;
    rd = v[65]; sc = v[1]; sp = v[0];
    f = '0;
    f[255:240] = {sc | sp, sc, sc & ~rd, sp, sp, 11'b0};
    if (sc) f[239:220] = {rd, v[64:58], 12'b0};
    if (sc && !rd) f[219:200] = {v[57:42], 4'b0};
    if (sp) begin
      f[199:180] = v[41:22];
      f[179:160] = v[21:2];
    end
    return f;
  endfunction

  function automatic logic [255:0] rx_frame(logic [40:0] v);
    logic [255:0] f;
    f = '0;
    f[255] = v[40];
    f[254:240] = 15'h5AA5;       // other tag bits: must not matter
    f[239:220] = 20'hA5A5A;      // slot 1 junk
    f[219:200] = 20'h3C3C3;      // slot 2 junk
    f[199:180] = v[39:20];
    f[179:160] = v[19:0];
    f[159:140] = 20'hFFFFF;      // slot 5 junk
    return f;
  endfunction

  // bench frame position and codec-side serial drive
  logic [7:0]   bp;
  logic [255:0] rx_next = '0, rx_cur0 = '0, rx_cur1 = '0;
  initial begin
    bp = 8'd255; sdi0 = 0; sdi1 = 0;
    forever begin
      @(posedge clk); #1;
      if (rst) bp = 8'd255;
      else begin
        if (bp == 8'd254) rx_cur1 = rx_next;
        if (bp == 8'd255) rx_cur0 = rx_next;
        bp = bp + 8'd1;
      end
      sdi0 = rx_cur0[8'd255 - bp];
      sdi1 = rx_cur1[8'd255 - (bp + 8'd1)];
    end
  end

  // codec-side frame collector and sync timing checks
  logic [255:0] cur, last;
  int frame_cnt = 0;
  initial begin
    automatic int idx = 0, hi = 0, period = 0;
    automatic bit ps = 0, seen = 0, coll = 0;
    cur = '0; last = '0;
    forever begin
      @(negedge clk);
      if (rst) begin ps = 0; seen = 0; coll = 0; hi = 0; period = 0; end
      else begin
        period++;
        if (sync0 && !ps) begin
          if (seen) chk(period == 256, "R1 frame period", period, 256);
          seen = 1; period = 0; idx = 0; coll = 1; hi = 0;
        end
        if (ps && !sync0) chk(hi == 16, "R1 sync high length", hi, 16);
        if (sync0) hi++;
        if (coll) begin
          cur[255 - idx] = sdo0;
          idx++;
          if (idx == 256) begin last = cur; frame_cnt++; coll = 0; end
        end
        ps = sync0;
        if (rv0) chk(bp == 8'd96, "R9 rec_valid position u0", bp, 96);
        if (rv1) chk(bp == 8'd95, "R7 rec_valid position early u1", bp, 95);
      end
    end
  end

  task automatic wait_frames(input int n);
    int t;
    t = frame_cnt + n;
    while (frame_cnt < t) @(negedge clk);
  endtask

  task automatic check_frame(input logic [255:0] e, input string tagname);
    chk(last[255:240] == e[255:240], {"R3 R2 tag ", tagname}, last[255:240], e[255:240]);
    chk(last[239:220] == e[239:220], {"R4 slot1 ", tagname}, last[239:220], e[239:220]);
    chk(last[219:200] == e[219:200], {"R4 slot2 ", tagname}, last[219:200], e[219:200]);
    chk(last[199:180] == e[199:180], {"R5 slot3 ", tagname}, last[199:180], e[199:180]);
    chk(last[179:160] == e[179:160], {"R5 slot4 ", tagname}, last[179:160], e[179:160]);
    chk(last[159:0] == '0, {"R5 slots5-12 zero ", tagname}, last[63:0], 0);
  endtask

  task automatic send(input logic [65:0] v);
    bit ca, pa;
    @(negedge clk);
    cmd_read = v[65]; cmd_addr = v[64:58]; cmd_data = v[57:42];
    pcm_left = v[41:22]; pcm_right = v[21:2];
    cmd_valid = v[1]; pcm_valid = v[0];
    while (cmd_valid || pcm_valid) begin
      ca = cmd_valid && cmd_ready;
      pa = pcm_valid && pcm_ready;
      @(negedge clk);
      if (ca) cmd_valid = 0;
      if (pa) pcm_valid = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk(sync0 == 0, "R1 reset sync low", sync0, 0);
    chk(sdo0 == 0, "R2 reset sdo low", sdo0, 0);
    chk(cmd_ready == 1 && pcm_ready == 1, "R6 reset ready", {cmd_ready, pcm_ready}, 2'b11);
    chk(rv0 == 0 && crdy0 == 0, "R9 R8 reset outputs", {rv0, crdy0}, 0);
    rst = 0;
    @(negedge clk);
    chk(sync0 == 1, "R1 sync high on first cycle after reset", sync0, 1);

    // idle frames carry nothing
    wait_frames(2);
    check_frame('0, "idle");

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      send(VEC[i]);
      if (VEC[i][1] || VEC[i][0]) begin
        while (!(cmd_ready && pcm_ready)) @(negedge clk);
        wait_frames(1);
      end else wait_frames(2);
      check_frame(exp_frame(VEC[i]), $sformatf("vec%0d", i));
    end

    // R6: ready held low until the frame start, second command waits
    send({1'b0, 7'h11, 16'h1234, 40'h0, 1'b1, 1'b0});
    chk(cmd_ready == 0, "R6 ready low after accept", cmd_ready, 0);
    cmd_valid = 1; cmd_read = 0; cmd_addr = 7'h55; cmd_data = 16'hBEEF;
    while (!cmd_ready) @(negedge clk);
    chk(bp == 8'd0 && sync0 == 1, "R6 ready returns at frame start", {bp, 7'b0, sync0}, 16'h0001);
    @(negedge clk);
    cmd_valid = 0;
    chk(cmd_ready == 0, "R6 second command accepted", cmd_ready, 0);
    wait_frames(1);
    chk(last[239:220] == {1'b0, 7'h11, 12'h0}, "R6 first command frame", last[239:220], {1'b0, 7'h11, 12'h0});
    wait_frames(1);
    chk(last[239:220] == {1'b0, 7'h55, 12'h0}, "R6 second command next frame", last[239:220], {1'b0, 7'h55, 12'h0});
    chk(last[219:200] == {16'hBEEF, 4'h0}, "R4 second command data", last[219:200], {16'hBEEF, 4'h0});

    // receive path, both alignments
    for (int k = 0; k < NRX; k++) begin
      rx_next = rx_frame(RXV[k]);
      wait_frames(3);
      chk(rl0 == RXV[k][39:20], "R9 rec_left u0", rl0, RXV[k][39:20]);
      chk(rr0 == RXV[k][19:0], "R9 rec_right u0", rr0, RXV[k][19:0]);
      chk(crdy0 == RXV[k][40], "R8 codec_ready u0", crdy0, RXV[k][40]);
      chk(rl1 == RXV[k][39:24], "R7 R9 rec_left early u1", rl1, RXV[k][39:24]);
      chk(rr1 == RXV[k][19:4], "R7 R9 rec_right early u1", rr1, RXV[k][19:4]);
      chk(crdy1 == RXV[k][40], "R7 R8 codec_ready early u1", crdy1, RXV[k][40]);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule